// File: doc/BRIEF.md
# Interrupt Source Event State Buffer

This block holds a bank of interrupt sources. Each source keeps a two-bit state, a "pending" bit (P) and a "queued" bit (Q), that folds repeated triggers together so that a given source is handed to the routing stage at most once until software ends the interrupt. Triggers come either from a per-source hardware line or from a store on the memory-mapped port. Level-sensitive sources also track whether their line is currently high. When the line is still high at end-of-interrupt, the event is raised again.

Software reaches each source through a window of 2^PAGE_SHIFT bytes of address space. Within the management page, bits [11:8] of the address select the operation: end-of-interrupt, inspect, inject, or force the state. Every load returns the state as it stood before the access. With PAGE_SHIFT of 13 or 17, the window is split in half. The lower half is a trigger-only page and the upper half is the management page. Forwarded events leave on a valid/ready notify stream that carries the source number.

Each of the two streams has its own back-pressure rule. A request is taken on a cycle where req_valid and req_ready are both high. req_ready is low only while a load response is waiting and rsp_ready is low. Stores produce no response. The notify stream holds notify_valid and notify_src steady until notify_ready is seen.

Top module: `esb_source_bank`

## Requirements
- R1: After reset, every source state is 00 and its asserted bit is 0, and rsp_valid and notify_valid are low.
- R2: A trigger moves state 00 to 10 and forwards one notify. States 10 and 11 become 11, and state 01 stays 01, with no notify. States are written as {P,Q}.
- R3: End-of-interrupt moves 10 and 01 to 00 without a notify, leaves 00 at 00, and moves 11 to 10 with one notify.
- R4: On a level source, a rising line triggers, and the line's registered level is returned as bit 2 of load data (value 4). An end-of-interrupt while that bit is set leaves the state at 10 and forwards a notify.
- R5: The source index is address bits above PAGE_SHIFT. In the management page, address bits [11:8] decode the operation. A load at 0x000 is end-of-interrupt. A load at 0x800 only reads. A store at 0x800 is a trigger. Loads at 0xC00, 0xD00, 0xE00 and 0xF00 force the state to 00, 01, 10 and 11, taken from address bits [9:8]. Any other access leaves the state unchanged.
- R6: A load returns {asserted,P,Q} as it stood at the start of the accepting cycle. rsp_valid rises on the next cycle, and the response stays stable with req_ready low until rsp_ready is high.
- R7: With PAGE_SHIFT of 13 or 17, address bit PAGE_SHIFT-1 selects the page, with 1 being the management page. A store to the trigger page triggers the source. A load there returns the state and changes nothing.
- R8: An access whose index is NUM_SRC or more changes no source. A load of that kind returns 0.
- R9: A source marked in BYPASS_MASK forwards a notify on every trigger and keeps its state unchanged.
- R10: notify_valid and notify_src hold until notify_ready. The lowest-numbered waiting source is issued first. Repeated forwards of one source that are still waiting merge into one notify.
- R11: A store at management offset 0x400 performs end-of-interrupt only on sources marked in STORE_EOI_MASK. On other sources it is ignored.
- R12: An edge source triggers once per rising edge of its hardware line. Holding the line high causes no further trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_line | input | NUM_SRC | Hardware interrupt line per source |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | PAGE_SHIFT+IDX_W+1 | Byte address of the access |
| rsp_valid | output | 1 | Load data valid |
| rsp_ready | input | 1 | Load data consumed |
| rsp_data | output | 3 | {asserted, P, Q} before the access |
| notify_valid | output | 1 | Notify stream valid |
| notify_ready | input | 1 | Notify stream accepted |
| notify_src | output | IDX_W | Source number being notified |

## Verification
The state machine is driven from each of its four states by inject stores, hardware edges, end-of-interrupt loads and forced-state loads. Reading back through the inspect offset distinguishes the merging transitions from the forwarding ones. A level source is held high across an end-of-interrupt and then lowered, which separates the re-raise path from the plain edge path. Several sources are fired while notify_ready is low. The resulting issue order shows lowest-first selection, and a bypass source fired twice in that window shows merging. Trigger-page loads, out-of-range indices and a store end-of-interrupt on a source without that capability confirm that those accesses leave the state as it was.

// File: rtl/esb_pkg.sv
package esb_pkg;

  localparam logic [1:0] PQ_RESET  = 2'b00;
  localparam logic [1:0] PQ_OFF    = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_QUEUED = 2'b11;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_TRIG = 2'd1,
    OP_EOI  = 2'd2,
    OP_SET  = 2'd3
  } esb_op_e;

  typedef struct packed {
    logic [1:0] pq;
    logic       fwd;
  } pq_step_t;

  function automatic pq_step_t pq_trigger(input logic [1:0] pq, input logic bypass);
    pq_step_t r;
    r.pq  = pq;
    r.fwd = 1'b0;
    if (bypass) begin
      r.fwd = 1'b1;
    end else begin
      case (pq)
        PQ_RESET: begin
          r.pq  = PQ_PEND;
          r.fwd = 1'b1;
        end
        PQ_PEND, PQ_QUEUED: r.pq = PQ_QUEUED;
        default: r.pq = pq;
      endcase
    end
    return r;
  endfunction

  function automatic pq_step_t pq_eoi(input logic [1:0] pq);
    pq_step_t r;
    if (pq == PQ_QUEUED) begin
      r.pq  = PQ_PEND;
      r.fwd = 1'b1;
    end else begin
      r.pq  = PQ_RESET;
      r.fwd = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/esb_addr_decode.sv
module esb_addr_decode
  import esb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PAGE_SHIFT = 13,
  parameter int IDX_W = 3,
  parameter int ADDR_W = 17,
  parameter logic [NUM_SRC-1:0] STORE_EOI_MASK = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  output logic [IDX_W-1:0]  src_idx,
  output logic              in_range,
  output esb_op_e           op,
  output logic [1:0]        set_val
);

  localparam int  PG_W     = ADDR_W - PAGE_SHIFT;
  localparam bit  TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

  logic [PG_W-1:0] page_no;
  logic            mgmt_page;
  logic [3:0]      off;
  logic            eoi_store_ok;

  assign page_no  = addr[ADDR_W-1:PAGE_SHIFT];
  assign src_idx  = page_no[IDX_W-1:0];
  assign in_range = (page_no < PG_W'(NUM_SRC));
  assign off      = addr[11:8];
  assign set_val  = addr[9:8];

  generate
    if (TWO_PAGE) begin : g_two_page
      assign mgmt_page = addr[PAGE_SHIFT-1];
    end else begin : g_one_page
      assign mgmt_page = 1'b1;
    end
  endgenerate

  always_comb begin
    eoi_store_ok = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_idx == IDX_W'(i)) eoi_store_ok = STORE_EOI_MASK[i];
    end
  end

  always_comb begin
    op = OP_NONE;
    if (!mgmt_page) begin
      op = write ? OP_TRIG : OP_NONE;
    end else begin
      case (off[3:2])
        2'b00: op = write ? OP_NONE : OP_EOI;
        2'b01: op = (write && eoi_store_ok) ? OP_EOI : OP_NONE;
        2'b10: op = write ? OP_TRIG : OP_NONE;
        default: op = write ? OP_NONE : OP_SET;
      endcase
    end
  end

endmodule

// File: rtl/esb_src_cell.sv
module esb_src_cell
  import esb_pkg::*;
#(
  parameter bit LEVEL = 1'b0,
  parameter bit BYPASS = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line,
  input  logic       op_en,
  input  esb_op_e    op,
  input  logic [1:0] set_val,
  output logic [2:0] status,
  output logic       fwd
);

  logic [1:0] pq_q;
  logic       line_q;
  logic       rise;
  pq_step_t   hw_s;
  pq_step_t   op_s;

  assign rise = line & ~line_q;

  always_comb begin
    hw_s.pq  = pq_q;
    hw_s.fwd = 1'b0;
    if (rise) hw_s = pq_trigger(pq_q, BYPASS);

    op_s.pq  = hw_s.pq;
    op_s.fwd = 1'b0;
    if (op_en) begin
      case (op)
        OP_TRIG: op_s = pq_trigger(hw_s.pq, BYPASS);
        OP_EOI: begin
          op_s = pq_eoi(hw_s.pq);
          if (LEVEL && line_q) begin
            op_s.pq  = PQ_PEND;
            op_s.fwd = 1'b1;
          end
        end
        OP_SET: op_s.pq = set_val;
        default: ;
      endcase
    end
  end

  assign fwd    = hw_s.fwd | op_s.fwd;
  assign status = {(LEVEL ? line_q : 1'b0), pq_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pq_q   <= PQ_RESET;
      line_q <= 1'b0;
    end else begin
      pq_q   <= op_s.pq;
      line_q <= line;
    end
  end

  // R2
  trig_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_TRIG && !rise && pq_q == PQ_RESET && !BYPASS)
      |=> (pq_q == PQ_PEND));

  // R3
  eoi_requeue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_EOI && !rise && pq_q == PQ_QUEUED) |-> fwd);

  // R5
  set_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_SET) |=> (pq_q == $past(set_val)));

  generate
    if (BYPASS) begin : g_byp_chk
      // R9
      bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_en && (op == OP_EOI || op == OP_SET)) |=> (pq_q == $past(pq_q)));
    end
  endgenerate

endmodule

// File: rtl/esb_notify_arb.sv
module esb_notify_arb #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] fwd_vec,
  output logic               notify_valid,
  input  logic               notify_ready,
  output logic [IDX_W-1:0]   notify_src
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] take_mask;
  logic [IDX_W-1:0]   pick;
  logic               slot_free;
  logic               load;
  logic               vld_q;
  logic [IDX_W-1:0]   src_q;

  always_comb begin
    pick = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = IDX_W'(i);
    end
  end

  assign slot_free = !vld_q || notify_ready;
  assign load      = slot_free && (|pend_q);

  always_comb begin
    take_mask = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      take_mask[i] = load && (pick == IDX_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      vld_q  <= 1'b0;
      src_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~take_mask) | fwd_vec;
      if (slot_free) vld_q <= |pend_q;
      if (load) src_q <= pick;
    end
  end

  assign notify_valid = vld_q;
  assign notify_src   = src_q;

  // R10
  notify_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_valid && !notify_ready) |=> (notify_valid && $stable(notify_src)));

  // R10
  notify_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> (int'(notify_src) < NUM_SRC));

endmodule

// File: rtl/esb_source_bank.sv
module esb_source_bank
  import esb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PAGE_SHIFT = 13,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'h80,
  parameter logic [NUM_SRC-1:0] BYPASS_MASK = 8'h40,
  parameter logic [NUM_SRC-1:0] STORE_EOI_MASK = 8'hDF,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W = PAGE_SHIFT + IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_line,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [2:0]         rsp_data,
  output logic               notify_valid,
  input  logic               notify_ready,
  output logic [IDX_W-1:0]   notify_src
);

  logic [IDX_W-1:0]   dec_idx;
  logic               dec_in_range;
  esb_op_e            dec_op;
  logic [1:0]         dec_set_val;
  logic               accept;
  logic [NUM_SRC-1:0] fwd_vec;
  logic [2:0]         status [NUM_SRC];
  logic [2:0]         sel_status;
  logic               rsp_vld_q;
  logic [2:0]         rsp_data_q;

  assign req_ready = !rsp_vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  esb_addr_decode #(
    .NUM_SRC(NUM_SRC),
    .PAGE_SHIFT(PAGE_SHIFT),
    .IDX_W(IDX_W),
    .ADDR_W(ADDR_W),
    .STORE_EOI_MASK(STORE_EOI_MASK)
  ) u_dec (
    .addr(req_addr),
    .write(req_write),
    .src_idx(dec_idx),
    .in_range(dec_in_range),
    .op(dec_op),
    .set_val(dec_set_val)
  );

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic sel;
      assign sel = accept && dec_in_range && (dec_idx == IDX_W'(g));
      esb_src_cell #(
        .LEVEL(LEVEL_MASK[g]),
        .BYPASS(BYPASS_MASK[g])
      ) u_cell (
        .clk(clk),
        .rst_n(rst_n),
        .line(hw_line[g]),
        .op_en(sel),
        .op(dec_op),
        .set_val(dec_set_val),
        .status(status[g]),
        .fwd(fwd_vec[g])
      );
    end
  endgenerate

  always_comb begin
    sel_status = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (dec_in_range && dec_idx == IDX_W'(i)) sel_status = status[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld_q  <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      if (accept && !req_write) begin
        rsp_vld_q  <= 1'b1;
        rsp_data_q <= sel_status;
      end else if (rsp_ready) begin
        rsp_vld_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_vld_q;
  assign rsp_data  = rsp_data_q;

  esb_notify_arb #(
    .NUM_SRC(NUM_SRC),
    .IDX_W(IDX_W)
  ) u_arb (
    .clk(clk),
    .rst_n(rst_n),
    .fwd_vec(fwd_vec),
    .notify_valid(notify_valid),
    .notify_ready(notify_ready),
    .notify_src(notify_src)
  );

  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R6
  rsp_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R8
  out_range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !dec_in_range) |=> (rsp_data == 3'b000));

endmodule

// File: tb/esb_source_bank_tb.sv
module esb_source_bank_tb_top;

  localparam int CLK_P = 10;
  localparam int NSRC = 8;
  localparam int SHIFT = 13;
  localparam int AW = SHIFT + 3 + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] hw_line = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [2:0]      rsp_data;
  logic            notify_valid;
  logic            notify_ready = 1'b1;
  logic [2:0]      notify_src;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  esb_source_bank dut_i (
    .clk(clk), .rst_n(rst_n), .hw_line(hw_line),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .notify_valid(notify_valid),
    .notify_ready(notify_ready), .notify_src(notify_src)
  );

  function automatic logic [AW-1:0] mg(input int s, input int off);
    return AW'((s << SHIFT) | (1 << (SHIFT - 1)) | off);
  endfunction

  function automatic logic [AW-1:0] tp(input int s, input int off);
    return AW'((s << SHIFT) | off);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ld(input logic [AW-1:0] a, output logic [2:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic st(input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ldchk(input string req, input logic [AW-1:0] a, input int exp);
    logic [2:0] d;
    ld(a, d);
    chk(req, int'(d), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected notify numbers as handshakes occur
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && notify_valid && notify_ready) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10: actual notify %0d expected none", notify_src);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(notify_src) != e) begin
          n_bad++;
          $display("FAIL R10: actual notify %0d expected %0d", notify_src, e);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] d;
    logic [2:0] s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 notify_valid", int'(notify_valid), 0);
    ldchk("R1 state", mg(2, 'h800), 0);

    // R2 trigger transitions
    exp_q.push_back(2);
    st(mg(2, 'h800));
    ldchk("R2 00->10", mg(2, 'h800), 2);
    st(mg(2, 'h800));
    ldchk("R2 10->11", mg(2, 'h800), 3);
    st(mg(2, 'h800));
    ldchk("R2 11->11", mg(2, 'h800), 3);
    ldchk("R5 set01 returns prior", mg(2, 'hD00), 3);
    ldchk("R5 set01", mg(2, 'h800), 1);
    st(mg(2, 'h800));
    ldchk("R2 01 stays", mg(2, 'h800), 1);

    // R3 end-of-interrupt transitions
    ldchk("R3 eoi on 01 returns prior", mg(2, 'h000), 1);
    ldchk("R3 01->00", mg(2, 'h800), 0);
    ldchk("R5 set11 returns prior", mg(2, 'hF00), 0);
    exp_q.push_back(2);
    ldchk("R3 eoi on 11 returns prior", mg(2, 'h000), 3);
    ldchk("R3 11->10", mg(2, 'h800), 2);
    ldchk("R3 eoi on 10", mg(2, 'h000), 2);
    ldchk("R3 10->00", mg(2, 'h800), 0);
    ldchk("R3 eoi on 00", mg(2, 'h000), 0);
    ldchk("R3 00 stays", mg(2, 'h800), 0);

    // R7 two-page layout
    exp_q.push_back(3);
    st(tp(3, 0));
    ldchk("R7 trigger page store", mg(3, 'h800), 2);
    ldchk("R7 trigger page load", tp(3, 'hC00), 2);
    ldchk("R7 trigger page load no change", mg(3, 'h800), 2);

    // R11 store EOI capability
    st(mg(3, 'h400));
    ldchk("R11 store eoi on capable", mg(3, 'h800), 0);
    ldchk("R11 set10 src5", mg(5, 'hE00), 0);
    st(mg(5, 'h400));
    ldchk("R11 store eoi ignored", mg(5, 'h800), 2);

    // R8 out-of-range index
    ldchk("R8 load out of range", AW'((1 << (SHIFT + 3)) | (1 << (SHIFT - 1)) | 'hE00), 0);
    st(AW'((1 << (SHIFT + 3)) | (1 << (SHIFT - 1)) | 'h800));
    ldchk("R8 src0 untouched", mg(0, 'h800), 0);

    // R12 edge hardware line
    exp_q.push_back(0);
    @(negedge clk); hw_line[0] = 1'b1;
    idle(2);
    ldchk("R12 rise triggers", mg(0, 'h800), 2);
    ldchk("R12 eoi", mg(0, 'h000), 2);
    idle(4);
    ldchk("R12 held high no retrigger", mg(0, 'h800), 0);
    @(negedge clk); hw_line[0] = 1'b0;
    idle(2);
    exp_q.push_back(0);
    @(negedge clk); hw_line[0] = 1'b1;
    idle(2);
    ldchk("R12 second rise", mg(0, 'h800), 2);

    // R4 level source
    exp_q.push_back(7);
    @(negedge clk); hw_line[7] = 1'b1;
    idle(2);
    ldchk("R4 asserted+pending", mg(7, 'h800), 6);
    exp_q.push_back(7);
    ldchk("R4 eoi while asserted", mg(7, 'h000), 6);
    ldchk("R4 re-raised", mg(7, 'h800), 6);
    idle(3);
    @(negedge clk); hw_line[7] = 1'b0;
    idle(2);
    ldchk("R4 line low", mg(7, 'h800), 2);
    ldchk("R4 final eoi", mg(7, 'h000), 2);
    ldchk("R4 idle", mg(7, 'h800), 0);

    // R9 bypass source
    exp_q.push_back(6);
    st(mg(6, 'h800));
    idle(3);
    exp_q.push_back(6);
    st(mg(6, 'h800));
    idle(3);
    ldchk("R9 state untouched", mg(6, 'h800), 0);

    // R10 ordering, hold and merge
    idle(4);
    @(negedge clk); notify_ready = 1'b0;
    st(mg(4, 'h800));
    st(mg(3, 'h800));
    st(mg(1, 'h800));
    st(mg(6, 'h800));
    st(mg(6, 'h800));
    idle(2);
    s0 = notify_src;
    chk("R10 valid held", int'(notify_valid), 1);
    idle(3);
    chk("R10 src stable", int'(notify_src), int'(s0));
    chk("R10 first issued", int'(notify_src), 4);
    exp_q.push_back(4);
    exp_q.push_back(1);
    exp_q.push_back(3);
    exp_q.push_back(6);
    @(negedge clk); notify_ready = 1'b1;
    idle(10);

    // R6 response back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    ld(mg(4, 'h800), d);
    chk("R6 load data", int'(d), 2);
    idle(3);
    chk("R6 rsp held", int'(rsp_valid), 1);
    chk("R6 data stable", int'(rsp_data), 2);
    chk("R6 req stalled", int'(req_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R6 rsp drained", int'(rsp_valid), 0);

    idle(20);
    chk("R10 all notifies seen", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule